// File: doc/BRIEF.md
# Count-Scheduled Stream Merge Arbiter

This block merges four producer streams into the write port of a single FIFO, following an order fixed in advance. The order is kept in a small scenario table. Each column of the table is one scenario, and it holds one word count for each input port. It also holds one extra entry, which is the number of times the scenario runs back to back. The arbiter serves the ports of a scenario in ascending port order and accepts exactly the listed number of words from each port. When it has run a column as many times as that column asks, it moves on to the next column.

The arbiter grants one port at a time, and only that port sees ready. Valid data on any other port never changes the order. The table is loaded through a simple write port while the block is idle. A start pulse then runs the whole schedule. When the last column has finished, a done flag goes high and every input stays not-ready until the next start pulse.

Top module: `sched_merge_arb`

## Requirements
- R1: While reset is active, and after reset until the first start pulse, every in_ready bit is 0, fifo_we is 0 and done is 0.
- R2: A write with cfg_we high stores cfg_val into column cfg_col. Rows 0 to 3 hold the word count of port 0 to 3, and row 4 holds the repeat count. The stored table is used from the next start pulse on, and a table written again between runs replaces the old schedule.
- R3: In the cycle after a start pulse, the first port with a non-zero count in the first runnable column is ready (when the FIFO is not full). A start pulse also clears done.
- R4: At most one in_ready bit is high in any cycle, and every in_ready bit is 0 while fifo_full is 1.
- R5: Within a scenario, the ports are served in ascending index order, with exactly their listed word counts. fifo_we is high exactly when the granted port's in_valid and in_ready are both high, and in that cycle fifo_wdata equals that port's in_data.
- R6: A column runs its scenario exactly as many times as its repeat count before any other column is served.
- R7: Columns run in ascending index order, and the next column starts only after every repetition of the previous one.
- R8: A port whose count is 0 gets no grant. The next non-zero port, or the next repetition or column, is ready in the cycle right after the last word, with no idle cycle in between.
- R9: A column whose repeat count is 0, or whose word counts are all 0, is skipped with no idle cycle. A table with no runnable column raises done in the cycle after start.
- R10: The order of words never depends on which non-granted ports have valid data. A non-granted port's in_valid has no effect.
- R11: After the last word of the last runnable column, done is 1 and all in_ready bits are 0 until the next start pulse, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_col | input | 2 | Column addressed by the write |
| cfg_row | input | 3 | Row 0..3 selects a port count, row 4 selects the repeat count |
| cfg_val | input | 8 | Value written |
| start | input | 1 | Pulse that starts the schedule from column 0 |
| in_valid | input | 4 | Per-port data valid |
| in_data | input | 64 | Per-port data, port p in bits 16p+15..16p |
| in_ready | output | 4 | Per-port ready, at most one bit set |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 16 | FIFO write data |
| done | output | 1 | Schedule finished |

## Verification
A wrong column, repetition or port pointer shows up at the next FIFO write as a word tagged with the wrong source port. A word counter that is off by one shows up as a grant that moves one word early or late. The bench tags every producer word with its port and a running index. Every FIFO write is compared with the sequence expanded from the table, so any such error is reported on the first word that goes astray. A skip that costs an extra cycle, or a done flag that comes too early or too late, is caught by counting write cycles against the total word count while every producer is valid and the FIFO has room.

// File: rtl/smarb_pkg.sv
// Shared types for the count-scheduled merge arbiter.
// Assumes nothing beyond standard SystemVerilog packages.
package smarb_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/smarb_matrix.sv
// Scenario table storage: one word count for each port and one repeat
// count for each column. Assumes that software writes only while the
// sequencer is idle or done. Rows past the repeat row are dropped.
module smarb_matrix #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_COLS  = 4,
    parameter int CNT_W     = 8,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int RW = $clog2(NUM_PORTS + 1)
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cfg_we,
    input  logic [CW-1:0]                              cfg_col,
    input  logic [RW-1:0]                              cfg_row,
    input  logic [CNT_W-1:0]                           cfg_val,
    output logic [NUM_COLS-1:0][NUM_PORTS-1:0][CNT_W-1:0] cnt_mat,
    output logic [NUM_COLS-1:0][CNT_W-1:0]             rep_vec
);
    // Table write: a count row or the repeat row of the addressed column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_mat <= '0;
            rep_vec <= '0;
        end else if (cfg_we && (int'(cfg_col) < NUM_COLS)) begin
            if (int'(cfg_row) < NUM_PORTS)
                cnt_mat[cfg_col][cfg_row[$clog2(NUM_PORTS)-1:0]] <= cfg_val;
            else if (int'(cfg_row) == NUM_PORTS)
                rep_vec[cfg_col] <= cfg_val;
        end
    end
endmodule

// File: rtl/smarb_seq.sv
// Schedule sequencer. It keeps a pointer (column, repetition, port) that
// always points at a slot with a non-zero word count, and it counts the
// words accepted in that slot. When the last word of a slot is accepted,
// it jumps straight to the next non-zero slot, so there is no idle cycle.
// Assumes the table does not change during a run.
module smarb_seq
    import smarb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_COLS  = 4,
    parameter int CNT_W     = 8,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start,
    input  logic                                       accept,
    input  logic [NUM_COLS-1:0][NUM_PORTS-1:0][CNT_W-1:0] cnt_mat,
    input  logic [NUM_COLS-1:0][CNT_W-1:0]             rep_vec,
    output logic                                       grant_vld,
    output logic [PW-1:0]                              grant_port,
    output logic                                       done
);
    typedef logic [NUM_PORTS-1:0][CNT_W-1:0]            col_cnt_t;
    typedef logic [NUM_COLS-1:0][NUM_PORTS-1:0][CNT_W-1:0] mat_t;
    typedef logic [NUM_COLS-1:0][CNT_W-1:0]             rep_t;

    seq_state_e      state;
    logic [CW-1:0]   cur_col;
    logic [PW-1:0]   cur_port;
    logic [CNT_W-1:0] cur_rep;
    logic [CNT_W-1:0] wcnt;

    // First port at or after 'from' with a non-zero count: {hit, port}.
    function automatic logic [PW:0] scan_col(input col_cnt_t cnts, input int from);
        logic          hit = 1'b0;
        logic [PW-1:0] pos = '0;
        for (int q = 0; q < NUM_PORTS; q++) begin
            if (!hit && q >= from && cnts[q] != '0) begin
                hit = 1'b1;
                pos = PW'(q);
            end
        end
        return {hit, pos};
    endfunction

    // First runnable column at or after 'from': {hit, col, port}.
    function automatic logic [CW+PW:0] col_search(input mat_t m, input rep_t r, input int from);
        logic          hit = 1'b0;
        logic [CW-1:0] col = '0;
        logic [PW-1:0] pos = '0;
        logic [PW:0]   sc;
        for (int c = 0; c < NUM_COLS; c++) begin
            sc = scan_col(m[c], 0);
            if (!hit && c >= from && r[c] != '0 && sc[PW]) begin
                hit = 1'b1;
                col = CW'(c);
                pos = sc[PW-1:0];
            end
        end
        return {hit, col, pos};
    endfunction

    logic [PW:0]    in_col, col_head;
    logic [CW+PW:0] later, first;
    logic           nxt_hit;
    logic [CW-1:0]  nxt_col;
    logic [PW-1:0]  nxt_port;
    logic [CNT_W-1:0] nxt_rep;
    logic [CNT_W-1:0] cur_cnt;
    logic           slot_last;

    // Successor slot of the current pointer, and the first slot of a run.
    always_comb begin
        in_col   = scan_col(cnt_mat[cur_col], int'(cur_port) + 1);
        col_head = scan_col(cnt_mat[cur_col], 0);
        later    = col_search(cnt_mat, rep_vec, int'(cur_col) + 1);
        first    = col_search(cnt_mat, rep_vec, 0);
        cur_cnt  = cnt_mat[cur_col][cur_port];
        slot_last = ({1'b0, wcnt} + 1'b1) == {1'b0, cur_cnt};
        if (in_col[PW]) begin
            nxt_hit  = 1'b1;
            nxt_col  = cur_col;
            nxt_rep  = cur_rep;
            nxt_port = in_col[PW-1:0];
        end else if (({1'b0, cur_rep} + 1'b1) < {1'b0, rep_vec[cur_col]}) begin
            nxt_hit  = 1'b1;
            nxt_col  = cur_col;
            nxt_rep  = cur_rep + 1'b1;
            nxt_port = col_head[PW-1:0];
        end else begin
            nxt_hit  = later[CW+PW];
            nxt_col  = later[CW+PW-1:PW];
            nxt_rep  = '0;
            nxt_port = later[PW-1:0];
        end
    end

    // Pointer, word counter and run state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            cur_col  <= '0;
            cur_port <= '0;
            cur_rep  <= '0;
            wcnt     <= '0;
        end else if (start) begin
            wcnt     <= '0;
            cur_rep  <= '0;
            cur_col  <= first[CW+PW-1:PW];
            cur_port <= first[PW-1:0];
            state    <= first[CW+PW] ? SEQ_RUN : SEQ_DONE;
        end else if (state == SEQ_RUN && accept) begin
            if (slot_last) begin
                wcnt <= '0;
                if (nxt_hit) begin
                    cur_col  <= nxt_col;
                    cur_rep  <= nxt_rep;
                    cur_port <= nxt_port;
                end else begin
                    state <= SEQ_DONE;
                end
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    assign grant_vld  = (state == SEQ_RUN);
    assign grant_port = cur_port;
    assign done       = (state == SEQ_DONE);

    // R8: a granted slot never has a zero word count.
    assert_slot_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> cnt_mat[cur_col][cur_port] != '0);
    // R5: words taken from a slot stay below its count.
    assert_word_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> wcnt < cnt_mat[cur_col][cur_port]);
    // R6: repetition index stays below the column's repeat count.
    assert_rep_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> cur_rep < rep_vec[cur_col]);
    // R11: done holds until a start pulse.
    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R7: the column pointer never moves backwards during a run.
    assert_col_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !start) |=> (!grant_vld || cur_col >= $past(cur_col)));
endmodule

// File: rtl/smarb_xbar.sv
// Grant steering: it raises ready on the granted port while the FIFO has
// room, and forwards that port's word to the FIFO write port. It is pure
// combinational logic with no state of its own.
module smarb_xbar #(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 16,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                                grant_vld,
    input  logic [PW-1:0]                       grant_port,
    input  logic                                fifo_full,
    input  logic [NUM_PORTS-1:0]                in_valid,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    in_data,
    output logic [NUM_PORTS-1:0]                in_ready,
    output logic                                fifo_we,
    output logic [DATA_W-1:0]                   fifo_wdata
);
    // One-hot ready toward the granted producer, and the write strobe.
    always_comb begin
        in_ready = '0;
        if (grant_vld && !fifo_full)
            in_ready[grant_port] = 1'b1;
        fifo_we    = |(in_ready & in_valid);
        fifo_wdata = in_data[grant_port];
    end
endmodule

// File: rtl/sched_merge_arb.sv
// Count-scheduled stream merge arbiter, top level. Producers use
// valid/ready handshakes, and the output drives a FIFO write port that
// has a full flag. The table is written while the block is idle, and
// start runs the schedule once.
module sched_merge_arb #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_COLS  = 4,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int RW = $clog2(NUM_PORTS + 1),
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CW-1:0]                 cfg_col,
    input  logic [RW-1:0]                 cfg_row,
    input  logic [CNT_W-1:0]              cfg_val,
    input  logic                          start,
    input  logic [NUM_PORTS-1:0]          in_valid,
    input  logic [NUM_PORTS*DATA_W-1:0]   in_data,
    output logic [NUM_PORTS-1:0]          in_ready,
    input  logic                          fifo_full,
    output logic                          fifo_we,
    output logic [DATA_W-1:0]             fifo_wdata,
    output logic                          done
);
    logic [NUM_COLS-1:0][NUM_PORTS-1:0][CNT_W-1:0] cnt_mat;
    logic [NUM_COLS-1:0][CNT_W-1:0]               rep_vec;
    logic [NUM_PORTS-1:0][DATA_W-1:0]             data_arr;
    logic                                         grant_vld;
    logic [PW-1:0]                                grant_port;

    assign data_arr = in_data;

    smarb_matrix #(.NUM_PORTS(NUM_PORTS), .NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_col(cfg_col),
        .cfg_row(cfg_row), .cfg_val(cfg_val), .cnt_mat(cnt_mat), .rep_vec(rep_vec)
    );

    smarb_seq #(.NUM_PORTS(NUM_PORTS), .NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(fifo_we),
        .cnt_mat(cnt_mat), .rep_vec(rep_vec), .grant_vld(grant_vld),
        .grant_port(grant_port), .done(done)
    );

    smarb_xbar #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_xbar (
        .grant_vld(grant_vld), .grant_port(grant_port), .fifo_full(fifo_full),
        .in_valid(in_valid), .in_data(data_arr), .in_ready(in_ready),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
    );

    // R11: no producer sees ready once the schedule has finished.
    assert_quiet_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready == '0);
    // R4: no FIFO write while the FIFO reports full.
    assert_no_write_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_we);
endmodule

// File: tb/sched_merge_arb_tb.sv
module sched_merge_arb_tb;
    localparam int P = 4;
    localparam int C = 4;
    localparam int W = 16;
    localparam int MAXW = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_col = '0;
    logic [2:0] cfg_row = '0;
    logic [7:0] cfg_val = '0;
    logic start = 1'b0;
    logic [P-1:0] in_valid = '0;
    logic [P*W-1:0] in_data;
    logic [P-1:0] in_ready;
    logic fifo_full = 1'b0;
    logic fifo_we;
    logic [W-1:0] fifo_wdata;
    logic done;

    int checks = 0;
    int failures = 0;
    int m_cnt [C][P];
    int m_rep [C];
    int exp_port [MAXW];
    int exp_n;
    logic [13:0] prod_idx [P];

    always #4 clk = ~clk;

    sched_merge_arb u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_col(cfg_col),
        .cfg_row(cfg_row), .cfg_val(cfg_val), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .fifo_full(fifo_full), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .done(done)
    );

    // Each producer word carries its port number and a running index.
    always_comb begin
        for (int p = 0; p < P; p++)
            in_data[p*W +: W] = {p[1:0], prod_idx[p]};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Expand the table into the expected sequence of source ports.
    function automatic void build_expected();
        exp_n = 0;
        for (int c = 0; c < C; c++)
            for (int r = 0; r < m_rep[c]; r++)
                for (int p = 0; p < P; p++)
                    for (int k = 0; k < m_cnt[c][p]; k++) begin
                        exp_port[exp_n] = p;
                        exp_n++;
                    end
    endfunction

    task automatic wr(input int c, input int r, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_col = 2'(c); cfg_row = 3'(r); cfg_val = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_matrix();
        for (int c = 0; c < C; c++) begin
            for (int p = 0; p < P; p++) wr(c, p, m_cnt[c][p]);
            wr(c, P, m_rep[c]);
        end
    endtask

    task automatic clear_matrix();
        for (int c = 0; c < C; c++) begin
            m_rep[c] = 0;
            for (int p = 0; p < P; p++) m_cnt[c][p] = 0;
        end
    endtask

    // Run one schedule. vprob/fprob are percentages for valid and full.
    task automatic run(input int vprob, input int fprob, input string tag,
                       output int stalls, output int cycles, output int first_we);
        int idx;
        int pend;
        int port;
        build_expected();
        idx = 0; stalls = 0; cycles = 0; pend = -1; first_we = -1;
        @(negedge clk);
        start = 1'b1;
        for (int guard = 0; guard < 20000; guard++) begin
            @(negedge clk);
            start = 1'b0;
            if (pend >= 0) prod_idx[pend] = prod_idx[pend] + 1'b1;
            pend = -1;
            for (int p = 0; p < P; p++)
                in_valid[p] = ($urandom_range(0, 99) < vprob);
            fifo_full = ($urandom_range(0, 99) < fprob);
            #1;
            if (done) break;
            cycles++;
            check($onehot0(in_ready), "R4", "ready not one-hot", int'(in_ready), 0);
            if (fifo_full)
                check(in_ready == '0, "R4", "ready while full", int'(in_ready), 0);
            check(fifo_we == |(in_valid & in_ready), "R5", "write strobe",
                  int'(fifo_we), int'(|(in_valid & in_ready)));
            if (fifo_we) begin
                port = 0;
                for (int p = 0; p < P; p++) if (in_ready[p]) port = p;
                if (first_we < 0) first_we = cycles;
                check(idx < exp_n, tag, "extra word index", idx, exp_n);
                if (idx < exp_n) begin
                    check(port == exp_port[idx], tag, "source port", port, exp_port[idx]);
                    check(fifo_wdata == {port[1:0], prod_idx[port]}, "R5", "write data",
                          int'(fifo_wdata), int'({port[1:0], prod_idx[port]}));
                end
                pend = port;
                idx++;
            end else begin
                stalls++;
            end
        end
        if (pend >= 0) prod_idx[pend] = prod_idx[pend] + 1'b1;
        check(idx == exp_n, "R11", "words before done", idx, exp_n);
        // R11: once done, inputs have no effect until a new start.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = '1;
            fifo_full = 1'b0;
            #1;
            check(done == 1'b1 && in_ready == '0 && !fifo_we, "R11", "quiet after done",
                  int'(in_ready), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int st, cy, fw;
        void'($urandom(32'd2024));
        for (int p = 0; p < P; p++) prod_idx[p] = '0;
        in_valid = '1;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == '0 && !fifo_we && !done, "R1", "outputs in reset",
              int'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(in_ready == '0 && !fifo_we && !done, "R1", "idle after reset",
              int'({in_ready, fifo_we, done}), 0);

        // R6 and R7: three ports of ten words repeated twice, then ten from port 2.
        clear_matrix();
        m_cnt[0][0] = 10; m_cnt[0][1] = 10; m_cnt[0][2] = 10; m_rep[0] = 2;
        m_cnt[1][2] = 10; m_rep[1] = 1;
        load_matrix();
        run(100, 0, "R7", st, cy, fw);
        check(st == 0 && cy == 70, "R6", "cycles for two columns", cy, 70);
        check(fw == 1, "R3", "first write in cycle after start", fw, 1);

        // R6: a single column repeated 24 times.
        clear_matrix();
        m_cnt[0][0] = 4; m_cnt[0][1] = 4; m_rep[0] = 24;
        load_matrix();
        run(100, 0, "R6", st, cy, fw);
        check(cy == 192, "R6", "cycles for 24 repeats", cy, 192);

        // R8: zero-count ports inside a column, no idle cycle.
        clear_matrix();
        m_cnt[0][1] = 3; m_cnt[0][3] = 2; m_rep[0] = 2;
        m_cnt[2][0] = 1; m_cnt[2][2] = 1; m_rep[2] = 3;
        load_matrix();
        run(100, 0, "R8", st, cy, fw);
        check(st == 0 && cy == 16, "R8", "no bubble on skip", cy, 16);

        // R9: a column with repeat 0 and a column with no counts are skipped.
        clear_matrix();
        m_cnt[0][0] = 5; m_rep[0] = 0;
        m_rep[1] = 3;
        m_cnt[2][3] = 2; m_cnt[2][1] = 1; m_rep[2] = 1;
        load_matrix();
        run(100, 0, "R9", st, cy, fw);
        check(cy == 3 && fw == 1, "R9", "skipped columns", cy, 3);

        // R9: an empty table finishes at once.
        clear_matrix();
        load_matrix();
        run(100, 0, "R9", st, cy, fw);
        check(cy == 0, "R9", "empty table cycles", cy, 0);

        // R2: rewriting the table changes the next run's schedule.
        clear_matrix();
        m_cnt[3][2] = 6; m_rep[3] = 1;
        load_matrix();
        run(100, 0, "R2", st, cy, fw);
        check(cy == 6, "R2", "rewritten table length", cy, 6);

        // R10 and R4: random tables, sparse valids and a busy FIFO.
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < C; c++) begin
                m_rep[c] = $urandom_range(0, 3);
                for (int p = 0; p < P; p++) m_cnt[c][p] = $urandom_range(0, 4);
            end
            load_matrix();
            run(30 + 10 * t, 25, "R10", st, cy, fw);
        end

        summary();
        $finish;
    end
endmodule